// File: doc/BRIEF.md
# PWM Timer Compare Output Unit

An 8-bit timer/counter with a single compare channel that drives one waveform pin. A 3-bit waveform mode picks the counting sequence, the counting ceiling (TOP) and the kind of waveform:
- free-running counting;
- clear-on-match counting, where the compare value is the ceiling;
- single-slope fast PWM;
- dual-slope phase-correct PWM.

A 2-bit output mode decides how the pin reacts to compare matches and to the counter's end points. What each output-mode code means depends on the waveform mode.

The two low waveform-mode bits and the output mode share one control byte. The third mode bit has its own write port. The compare value has a third write port. In the PWM modes the compare value is double-buffered, so a value written mid-period cannot cut a pulse short. When the compare value equals TOP and the high output-mode bit is set, the match is ignored. The pin then settles to a constant level, driven at the counter's low end in fast PWM and at its high end in phase-correct PWM.

Top module: `pwm_cmp_timer`

## Requirements
- R1: While reset is asserted, the counter reads 0, the control byte reads 0, and both `wave_oe` and `wave_out` are 0.
- R2: The waveform mode is {mode bit 2, control bits 1:0}:
  - 000: counts 0..255 and wraps.
  - 010: counts up to the compare value, then returns to 0.
  - 011: counts 0..255 and wraps.
  - 001: counts 0 up to 255 and back down to 0. Each end value is held for one cycle only.
  - 1xx: behaves as 000.
- R3: The control byte holds the output mode in bits 7:6 and the low mode bits in bits 1:0. Bits 5:2 are ignored on write and read back as 0.
- R4: In modes 000 and 010, a compare match acts on the output as follows: output mode 01 toggles it, 10 clears it and 11 sets it.
- R5: In mode 011, output mode 10 clears the output on a match and sets it when the counter is 0. Output mode 11 does the reverse. When the compare value is 0, the match takes priority over the low-end action.
- R6: In mode 001, output mode 10 clears the output on a match while the count rises and sets it on a match while the count falls. Output mode 11 does the reverse. At count 0 the slope counts as rising, and at TOP as falling.
- R7: In mode 011 with the compare value at TOP and output mode 1x, the match is ignored. The low-end action alone sets the level: constantly high for 10, constantly low for 11.
- R8: In mode 001 with the compare value at TOP and output mode 1x, the match is ignored. At TOP the output is set for 10 and cleared for 11.
- R9: `wave_oe` is 0 for output mode 00 in every waveform mode, and for output mode 01 in the PWM modes. While `wave_oe` is 0, `wave_out` is 0.
- R10: In the PWM modes, a compare write takes effect at the clock edge on which the counter stands at TOP. In the other modes it takes effect at the next edge.
- R11: The output register changes on the same clock edge on which the counter leaves the event value. For example, in fast PWM with output mode 10 and compare value 64, `wave_out` is high while the count is 1..64 and low from 65 on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_a_we | input | 1 | Write strobe for the control byte |
| cfg_a_wdata | input | 8 | Control byte: [7:6] output mode, [1:0] low mode bits |
| cfg_a_rdata | output | 8 | Control byte read-back, reserved bits zero |
| cfg_b_we | input | 1 | Write strobe for mode bit 2 |
| cfg_b_wdata | input | 1 | Mode bit 2 |
| cmp_we | input | 1 | Write strobe for the compare value |
| cmp_wdata | input | 8 | Compare value |
| cnt_val | output | 8 | Current counter value |
| wave_out | output | 1 | Waveform output |
| wave_oe | output | 1 | High when the waveform drives the pin |

## Verification
The embedded properties check the following on every cycle:
- the counter moves by exactly one step in dual-slope mode, and wraps from 255 to 0 in the single-slope modes;
- the active compare value changes only at TOP while buffered, and follows a write one edge later otherwise;
- the output is set after a fast-PWM low end, set at TOP in the phase-correct corner case, and flips on a toggle match.

Duty cycles for each output mode and compare value, control-byte read-back, the exact sample at which the pin changes, and the effect of a mid-period compare write on the running pulse are shown only by the bench's scenarios.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

  typedef enum logic [1:0] {
    WG_NORMAL = 2'd0,
    WG_PHASE  = 2'd1,
    WG_CTC    = 2'd2,
    WG_FAST   = 2'd3
  } wg_kind_e;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_TGL  = 2'd3
  } pin_act_e;

  // control byte layout
  localparam int          CFG_W        = 8;
  localparam int          COM_LSB      = 6;
  localparam int          MODE_LSB     = 0;
  localparam logic [CFG_W-1:0] CFG_A_MASK = 8'hC3;

  function automatic wg_kind_e decode_wg(input logic [2:0] m);
    if (m[2]) return WG_NORMAL;
    case (m[1:0])
      2'd1:    return WG_PHASE;
      2'd2:    return WG_CTC;
      2'd3:    return WG_FAST;
      default: return WG_NORMAL;
    endcase
  endfunction

  function automatic logic is_pwm(input wg_kind_e k);
    return (k == WG_PHASE) || (k == WG_FAST);
  endfunction

  function automatic logic apply_act(input logic cur, input pin_act_e a);
    case (a)
      ACT_CLR: return 1'b0;
      ACT_SET: return 1'b1;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic output_enabled(input wg_kind_e k, input logic [1:0] com);
    if (com == 2'b00) return 1'b0;
    if (is_pwm(k) && com == 2'b01) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/pwm_cmp_counter.sv
module pwm_cmp_counter
  import pwm_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  wg_kind_e     kind,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt,
  output logic         at_top,
  output logic         at_bottom,
  output logic         slope_up
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic dir_up;

  function automatic logic [W-1:0] step(input wg_kind_e k, input logic [W-1:0] c,
                                        input logic top_hit, input logic up);
    if (k == WG_PHASE) return up ? c + ONE : c - ONE;
    return top_hit ? '0 : c + ONE;
  endfunction

  always_comb begin
    at_top    = (cnt == top_val);
    at_bottom = (cnt == '0);
    if (kind != WG_PHASE) slope_up = 1'b1;
    else if (at_bottom)   slope_up = 1'b1;
    else if (at_top)      slope_up = 1'b0;
    else                  slope_up = dir_up;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else begin
      cnt    <= step(kind, cnt, at_top, slope_up);
      dir_up <= (kind == WG_PHASE) ? slope_up : 1'b1;
    end
  end

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && kind == WG_PHASE && $past(kind) == WG_PHASE)
      |-> ((cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE)));

  // R2
  single_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt) == MAXV &&
     ($past(kind) == WG_FAST || $past(kind) == WG_NORMAL))
      |-> (cnt == '0));

endmodule

// File: rtl/pwm_cmp_ocr.sv
module pwm_cmp_ocr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         buffered,
  input  logic         load,
  output logic [W-1:0] ocr_act
);

  logic [W-1:0] ocr_buf;

  always_ff @(posedge clk) begin
    if (rst) begin
      ocr_buf <= '0;
      ocr_act <= '0;
    end else begin
      if (we) ocr_buf <= wdata;
      if (!buffered) begin
        if (we) ocr_act <= wdata;
      end else if (load) begin
        ocr_act <= ocr_buf;
      end
    end
  end

  // R10
  hold_until_top_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(buffered) && !$past(load)) |-> $stable(ocr_act));

  // R10
  direct_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!buffered && we) |=> (ocr_act == $past(wdata)));

endmodule

// File: rtl/pwm_cmp_wave.sv
module pwm_cmp_wave
  import pwm_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  wg_kind_e     kind,
  input  logic [1:0]   com,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] ocr_act,
  input  logic [W-1:0] top_val,
  input  logic         at_top,
  input  logic         at_bottom,
  input  logic         slope_up,
  output logic         wave_out,
  output logic         wave_oe
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic     wave_q;
  logic     match;
  logic     top_case;
  pin_act_e act;

  always_comb begin
    match    = (cnt == ocr_act);
    top_case = is_pwm(kind) && com[1] && (ocr_act == top_val);
    act      = ACT_KEEP;
    case (kind)
      WG_FAST: begin
        if (com[1]) begin
          if (match && !top_case) act = com[0] ? ACT_SET : ACT_CLR;
          else if (at_bottom)     act = com[0] ? ACT_CLR : ACT_SET;
        end
      end
      WG_PHASE: begin
        if (com[1]) begin
          if (top_case) begin
            if (at_top) act = com[0] ? ACT_CLR : ACT_SET;
          end else if (match) begin
            act = (slope_up ^ com[0]) ? ACT_CLR : ACT_SET;
          end
        end
      end
      default: begin
        if (match) begin
          case (com)
            2'b01:   act = ACT_TGL;
            2'b10:   act = ACT_CLR;
            2'b11:   act = ACT_SET;
            default: act = ACT_KEEP;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) wave_q <= 1'b0;
    else     wave_q <= apply_act(wave_q, act);
  end

  assign wave_oe  = output_enabled(kind, com);
  assign wave_out = wave_oe & wave_q;

  // R5
  fast_bottom_set_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == WG_FAST && com == 2'b10 && at_bottom && ocr_act != '0) |=> wave_q);

  // R8
  phase_top_case_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == WG_PHASE && com == 2'b10 && at_top && ocr_act == MAXV) |=> wave_q);

  // R4
  toggle_match_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_pwm(kind) && com == 2'b01 && cnt == ocr_act) |=> (wave_q != $past(wave_q)));

endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_a_we,
  input  logic [CFG_W-1:0] cfg_a_wdata,
  output logic [CFG_W-1:0] cfg_a_rdata,
  input  logic             cfg_b_we,
  input  logic             cfg_b_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cnt_val,
  output logic             wave_out,
  output logic             wave_oe
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CFG_W-1:0] cfg_a_q;
  logic             mode_hi_q;
  wg_kind_e         kind;
  logic [1:0]       com;
  logic [CNT_W-1:0] ocr_act;
  logic [CNT_W-1:0] top_val;
  logic             at_top;
  logic             at_bottom;
  logic             slope_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_a_q   <= '0;
      mode_hi_q <= 1'b0;
    end else begin
      if (cfg_a_we) cfg_a_q   <= cfg_a_wdata;
      if (cfg_b_we) mode_hi_q <= cfg_b_wdata;
    end
  end

  assign cfg_a_rdata = cfg_a_q & CFG_A_MASK;
  assign com         = cfg_a_q[COM_LSB +: 2];
  assign kind        = decode_wg({mode_hi_q, cfg_a_q[MODE_LSB +: 2]});
  assign top_val     = (kind == WG_CTC) ? ocr_act : MAXV;

  pwm_cmp_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .top_val   (top_val),
    .cnt       (cnt_val),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .slope_up  (slope_up)
  );

  pwm_cmp_ocr #(.W(CNT_W)) u_ocr (
    .clk      (clk),
    .rst      (rst),
    .we       (cmp_we),
    .wdata    (cmp_wdata),
    .buffered (is_pwm(kind)),
    .load     (at_top),
    .ocr_act  (ocr_act)
  );

  pwm_cmp_wave #(.W(CNT_W)) u_wave (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .com       (com),
    .cnt       (cnt_val),
    .ocr_act   (ocr_act),
    .top_val   (top_val),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .slope_up  (slope_up),
    .wave_out  (wave_out),
    .wave_oe   (wave_oe)
  );

endmodule

// File: tb/pwm_cmp_timer_test.sv
`timescale 1ns/1ps
module pwm_cmp_timer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_a_we = 1'b0;
  logic [7:0] cfg_a_wdata = '0;
  logic [7:0] cfg_a_rdata;
  logic       cfg_b_we = 1'b0;
  logic       cfg_b_wdata = 1'b0;
  logic       cmp_we = 1'b0;
  logic [7:0] cmp_wdata = '0;
  logic [7:0] cnt_val;
  logic       wave_out;
  logic       wave_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwm_cmp_timer uut (
    .clk(clk), .rst(rst),
    .cfg_a_we(cfg_a_we), .cfg_a_wdata(cfg_a_wdata), .cfg_a_rdata(cfg_a_rdata),
    .cfg_b_we(cfg_b_we), .cfg_b_wdata(cfg_b_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .cnt_val(cnt_val), .wave_out(wave_out), .wave_oe(wave_oe)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic [1:0] com;
    logic [7:0] ocr;
    logic [9:0] win;
    logic [9:0] high;
    logic       oe;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'b011, 2'b10, 8'd64,  10'd256, 10'd64,  1'b1, 4'd5},  // R5
    '{3'b011, 2'b11, 8'd64,  10'd256, 10'd192, 1'b1, 4'd5},  // R5
    '{3'b011, 2'b10, 8'd0,   10'd256, 10'd0,   1'b1, 4'd5},  // R5
    '{3'b011, 2'b10, 8'd255, 10'd256, 10'd256, 1'b1, 4'd7},  // R7
    '{3'b011, 2'b11, 8'd255, 10'd256, 10'd0,   1'b1, 4'd7},  // R7
    '{3'b001, 2'b10, 8'd100, 10'd510, 10'd200, 1'b1, 4'd6},  // R6
    '{3'b001, 2'b11, 8'd100, 10'd510, 10'd310, 1'b1, 4'd6},  // R6
    '{3'b001, 2'b10, 8'd255, 10'd510, 10'd510, 1'b1, 4'd8},  // R8
    '{3'b001, 2'b11, 8'd255, 10'd510, 10'd0,   1'b1, 4'd8},  // R8
    '{3'b001, 2'b11, 8'd0,   10'd510, 10'd510, 1'b1, 4'd6},  // R6
    '{3'b001, 2'b01, 8'd50,  10'd510, 10'd0,   1'b0, 4'd9},  // R9
    '{3'b011, 2'b00, 8'd64,  10'd256, 10'd0,   1'b0, 4'd9},  // R9
    '{3'b010, 2'b01, 8'd9,   10'd20,  10'd10,  1'b1, 4'd4},  // R4
    '{3'b000, 2'b01, 8'd7,   10'd512, 10'd256, 1'b1, 4'd4},  // R4
    '{3'b010, 2'b11, 8'd9,   10'd20,  10'd20,  1'b1, 4'd4}   // R4
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_a(input logic [7:0] d);
    @(negedge clk);
    cfg_a_we = 1'b1; cfg_a_wdata = d;
    @(negedge clk);
    cfg_a_we = 1'b0;
  endtask

  task automatic wr_b(input logic d);
    @(negedge clk);
    cfg_b_we = 1'b1; cfg_b_wdata = d;
    @(negedge clk);
    cfg_b_we = 1'b0;
  endtask

  task automatic wr_cmp(input logic [7:0] d);
    @(negedge clk);
    cmp_we = 1'b1; cmp_wdata = d;
    @(negedge clk);
    cmp_we = 1'b0;
  endtask

  task automatic wait_cnt(input string req, input logic [7:0] v);
    int n = 0;
    @(negedge clk);
    while (cnt_val != v && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (cnt_val != v) begin
      checks++; fails++;
      $display("FAIL %s count wait: actual %0d expected %0d", req, cnt_val, v);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "count",   cnt_val,     0);
    chk("R1", "ctrl",    cfg_a_rdata, 0);
    chk("R1", "oe",      wave_oe,     0);
    chk("R1", "out",     wave_out,    0);
    rst = 1'b0;

    // table walk: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int   hi;
      string tag;
      v   = VECS[i];
      hi  = 0;
      tag = $sformatf("R%0d", v.req);
      do_reset();
      wr_cmp(v.ocr);
      wr_b(v.mode[2]);
      wr_a({v.com, 4'b0000, v.mode[1:0]});
      repeat (2 * int'(v.win) + 8) @(negedge clk);
      for (int k = 0; k < int'(v.win); k++) begin
        @(negedge clk);
        if (wave_out) hi++;
      end
      chk(tag, $sformatf("vec %0d high cycles", i), hi, int'(v.high));
      chk(tag, $sformatf("vec %0d oe", i), wave_oe, int'(v.oe));
    end

    // R3: reserved bits read zero
    do_reset();
    wr_a(8'hFF);
    chk("R3", "ctrl readback", cfg_a_rdata, 8'hC3);

    // R2 and R10: clear-on-match sequence, compare write direct in non-PWM mode
    do_reset();
    wr_cmp(8'd3);
    wr_a(8'h02);
    wait_cnt("R2", 8'd0);
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      chk("R2", "ctc count", cnt_val, k % 4);
    end

    // R2: dual-slope turning points
    do_reset();
    wr_a(8'h01);
    wait_cnt("R2", 8'hFF);
    @(negedge clk); chk("R2", "phase after top", cnt_val, 8'hFE);
    @(negedge clk); chk("R2", "phase falling",   cnt_val, 8'hFD);
    wait_cnt("R2", 8'h00);
    @(negedge clk); chk("R2", "phase after bottom", cnt_val, 1);
    @(negedge clk); chk("R2", "phase rising",       cnt_val, 2);

    // R2: single-slope wrap
    do_reset();
    wr_a(8'h03);
    wait_cnt("R2", 8'hFF);
    @(negedge clk); chk("R2", "fast wrap", cnt_val, 0);

    // R2: mode 1xx behaves as free-running
    do_reset();
    wr_b(1'b1);
    wr_a(8'h01);
    wait_cnt("R2", 8'hFF);
    @(negedge clk); chk("R2", "mode 1xx wrap", cnt_val, 0);

    // R11: exact edge of output change in fast PWM, output mode 10, compare 64
    do_reset();
    wr_cmp(8'd64);
    wr_a(8'h83);
    wait_cnt("R11", 8'd0);
    @(negedge clk); chk("R11", "out at count 1", wave_out, 1);
    wait_cnt("R11", 8'd64);
    chk("R11", "out at count 64", wave_out, 1);
    @(negedge clk); chk("R11", "out at count 65", wave_out, 0);
    wait_cnt("R11", 8'd0);
    chk("R11", "out at count 0", wave_out, 0);

    // R10: mid-period write held until TOP
    do_reset();
    wr_cmp(8'd100);
    wr_a(8'h83);
    wait_cnt("R10", 8'd0);
    wait_cnt("R10", 8'd10);
    cmp_we = 1'b1; cmp_wdata = 8'd20;
    @(negedge clk);
    cmp_we = 1'b0;
    wait_cnt("R10", 8'd50);
    chk("R10", "old compare still active", wave_out, 1);
    wait_cnt("R10", 8'd0);
    wait_cnt("R10", 8'd50);
    chk("R10", "new compare after top", wave_out, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule